// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block sits between the per-channel cycle-by-cycle overcurrent comparators of a six-channel PWM power stage and the PWM generator. Every clock it looks at the overcurrent flags of all channels. It records any fault in a sticky status bit and in a per-channel capture mask, and it drives an active-low alert. It also decides whether the PWM generator may keep switching.

Three reactions are available. The first only flags the fault and keeps switching. The second, hiccup, stops switching and restarts by itself once the fault has been gone for a programmable number of clock cycles. The third, latch-off, stops switching until the PWM enable input is toggled or chip enable is cycled. The reaction comes from a register response field when the override bit is set. Otherwise it comes from an external mode-pin setting. The register field's default of 00 selects flag-only.

Top module: `ocp_resp_ctrl`

## Requirements
- R1: The active 2-bit response code decodes as follows: 00 and 11 select flag-only, 01 selects hiccup, and 10 selects latch-off.
- R2: When `resp_ovr_en` is 1, the response code is taken from `resp_reg`. When it is 0, the code is taken from `resp_pin` and `resp_reg` has no effect.
- R3: If any bit of `chan_oc` is sampled high at a clock edge, `flt_sticky` reads 1 and `alert_n` reads 0 after that edge. Both then hold until a clear. After reset, `flt_sticky` is 0 and `alert_n` is 1.
- R4: Bit i of `flt_mask` is set after any edge at which `chan_oc[i]` is sampled high. The mask accumulates the OR of all channel faults since the last clear.
- R5: After an edge with `clr_fault` high, `flt_sticky`, `flt_mask` and `alert_n` show only the faults sampled at that same edge. A fault present at the clearing edge wins over the clear.
- R6: In flag-only mode a fault never drops `gate_en`.
- R7: In hiccup mode `gate_en` goes low in the same cycle that a fault is present. It returns high after RESTART_CYC consecutive edges with no channel fault.
- R8: In hiccup mode, a fault present during the restart wait sets the wait back to zero.
- R9: In latch-off mode `gate_en` goes low in the same cycle that a fault is present. It stays low until an edge at which `pwm_en` is high, was low at the previous edge, and no channel fault is present.
- R10: While `chip_en` is 0, `gate_en` is 0 and the controller returns to its running state. The status bits are unchanged by this. `gate_en` also requires `pwm_en` to be high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_oc | input | NCH | Per-channel overcurrent detect flags |
| resp_reg | input | 2 | Response code from the register field |
| resp_ovr_en | input | 1 | 1 selects the register code, 0 selects the pin code |
| resp_pin | input | 2 | Response code from the external mode pins |
| pwm_en | input | 1 | PWM enable; a low-to-high toggle recovers from latch-off |
| chip_en | input | 1 | Chip enable; low forces the gate off and resets the response state |
| clr_fault | input | 1 | Single-cycle pulse that clears the status, mask and alert |
| gate_en | output | 1 | PWM switching allowed |
| flt_sticky | output | 1 | Sticky fault status |
| flt_mask | output | NCH | Accumulated mask of the channels that faulted |
| alert_n | output | 1 | Active-low alert |

## Verification
A wrong response state shows up on `gate_en` at once. Either gating stays off when it should be on, or switching goes on while a stop response is still pending. The first fault-free cycle that follows exposes it. A restart counter that is off by even one step shifts the hiccup recovery edge by one cycle, so the bench compares `gate_en` in every cycle of the wait. Capture errors in the sticky bit or the mask become visible one edge after the fault or the clear that should have set or cleared them.

// File: rtl/ocp_pkg.sv
`timescale 1ns/100ps
package ocp_pkg;

   typedef enum logic [1:0] {
      RESP_FLAG   = 2'd0,
      RESP_HICCUP = 2'd1,
      RESP_LATCH  = 2'd2
   } resp_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_WAIT  = 2'd1,
      ST_LATCH = 2'd2
   } state_e;

   // the unused code 11 falls back to flag-only
   function automatic resp_e decode_resp(input logic [1:0] code);
      case (code)
         2'b01:   return RESP_HICCUP;
         2'b10:   return RESP_LATCH;
         default: return RESP_FLAG;
      endcase
   endfunction

endpackage

// File: rtl/ocp_mode_sel.sv
`timescale 1ns/100ps
module ocp_mode_sel
   import ocp_pkg::*;
#(
   parameter int CODE_W = 2
) (
   input  logic [CODE_W-1:0] resp_reg,
   input  logic              resp_ovr_en,
   input  logic [CODE_W-1:0] resp_pin,
   output resp_e             mode
);

   if (CODE_W != 2) begin : g_bad_code_w
      $error("ocp_mode_sel: CODE_W must be 2");
   end

   logic [CODE_W-1:0] code_sel;

   always_comb begin
      code_sel = resp_ovr_en ? resp_reg : resp_pin;
      mode     = decode_resp(code_sel);
   end

endmodule

// File: rtl/ocp_status.sv
`timescale 1ns/100ps
module ocp_status #(
   parameter int NCH = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] chan_oc,
   input  logic           clr_fault,
   output logic           flt_sticky,
   output logic [NCH-1:0] flt_mask,
   output logic           alert_n
);

   if (NCH < 1) begin : g_bad_nch
      $error("ocp_status: NCH must be at least 1");
   end

   logic any_oc;
   assign any_oc = |chan_oc;

   for (genvar i = 0; i < NCH; i++) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flt_mask[i] <= 1'b0;
         else if (clr_fault) flt_mask[i] <= chan_oc[i];
         else                flt_mask[i] <= flt_mask[i] | chan_oc[i];
      end

      // R4
      mask_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         chan_oc[i] |=> flt_mask[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flt_sticky <= 1'b0;
      else if (clr_fault) flt_sticky <= any_oc;
      else if (any_oc)    flt_sticky <= 1'b1;
   end

   assign alert_n = ~flt_sticky;

   // R3
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_sticky && !clr_fault |=> flt_sticky);

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fault && !any_oc |=> !flt_sticky && alert_n);

endmodule

// File: rtl/ocp_restart_timer.sv
`timescale 1ns/100ps
module ocp_restart_timer #(
   parameter int RESTART_CYC = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic fault,
   output logic done
);

   if (RESTART_CYC < 1) begin : g_bad_restart
      $error("ocp_restart_timer: RESTART_CYC must be at least 1");
   end

   if (RESTART_CYC == 1) begin : g_nocnt
      assign done = waiting & ~fault;
   end else begin : g_cnt
      localparam int CW = $clog2(RESTART_CYC);
      localparam logic [CW-1:0] LAST = CW'(RESTART_CYC - 1);

      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   cnt <= '0;
         else if (!waiting || fault)   cnt <= '0;
         else if (cnt != LAST)         cnt <= cnt + 1'b1;
         else                          cnt <= '0;
      end

      assign done = waiting & ~fault & (cnt == LAST);

      // R8
      fault_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         waiting && fault |=> cnt == '0);
   end

endmodule

// File: rtl/ocp_resp_fsm.sv
`timescale 1ns/100ps
module ocp_resp_fsm
   import ocp_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   any_oc,
   input  resp_e  mode,
   input  logic   chip_en,
   input  logic   pwm_en,
   input  logic   tmr_done,
   output state_e state,
   output logic   gate_en
);

   state_e state_nxt;
   logic   pwm_en_q;
   logic   pwm_rise;
   logic   stop_now;

   assign pwm_rise = pwm_en & ~pwm_en_q;
   assign stop_now = any_oc & (mode != RESP_FLAG);

   always_comb begin
      state_nxt = state;
      if (!chip_en) begin
         state_nxt = ST_RUN;
      end else begin
         case (state)
            ST_RUN: begin
               if (any_oc && mode == RESP_HICCUP)     state_nxt = ST_WAIT;
               else if (any_oc && mode == RESP_LATCH) state_nxt = ST_LATCH;
            end
            ST_WAIT:  if (tmr_done)             state_nxt = ST_RUN;
            ST_LATCH: if (pwm_rise && !any_oc)  state_nxt = ST_RUN;
            default:                            state_nxt = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         pwm_en_q <= 1'b0;
      end else begin
         state    <= state_nxt;
         pwm_en_q <= pwm_en;
      end
   end

   assign gate_en = chip_en & pwm_en & (state == ST_RUN) & ~stop_now;

   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_LATCH && chip_en && !(pwm_en && !pwm_en_q) |=> state == ST_LATCH);

   // R10
   chip_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> state == ST_RUN);

   // R6
   flag_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RUN && mode == RESP_FLAG |=> state == ST_RUN);

   // R7
   wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WAIT && any_oc && chip_en |=> state == ST_WAIT);

endmodule

// File: rtl/ocp_resp_ctrl.sv
`timescale 1ns/100ps
module ocp_resp_ctrl
   import ocp_pkg::*;
#(
   parameter int NCH         = 6,
   parameter int RESTART_CYC = 50_000_000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] chan_oc,
   input  logic [1:0]     resp_reg,
   input  logic           resp_ovr_en,
   input  logic [1:0]     resp_pin,
   input  logic           pwm_en,
   input  logic           chip_en,
   input  logic           clr_fault,
   output logic           gate_en,
   output logic           flt_sticky,
   output logic [NCH-1:0] flt_mask,
   output logic           alert_n
);

   if (NCH < 1 || NCH > 64) begin : g_bad_nch
      $error("ocp_resp_ctrl: NCH out of range");
   end

   resp_e  mode;
   state_e state;
   logic   any_oc;
   logic   tmr_done;

   assign any_oc = |chan_oc;

   ocp_mode_sel #(.CODE_W(2)) u_mode (
      .resp_reg    (resp_reg),
      .resp_ovr_en (resp_ovr_en),
      .resp_pin    (resp_pin),
      .mode        (mode)
   );

   ocp_status #(.NCH(NCH)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_oc    (chan_oc),
      .clr_fault  (clr_fault),
      .flt_sticky (flt_sticky),
      .flt_mask   (flt_mask),
      .alert_n    (alert_n)
   );

   ocp_restart_timer #(.RESTART_CYC(RESTART_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (state == ST_WAIT),
      .fault   (any_oc),
      .done    (tmr_done)
   );

   ocp_resp_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_oc   (any_oc),
      .mode     (mode),
      .chip_en  (chip_en),
      .pwm_en   (pwm_en),
      .tmr_done (tmr_done),
      .state    (state),
      .gate_en  (gate_en)
   );

endmodule

// File: tb/ocp_resp_ctrl_bench.sv
`timescale 1ns/100ps
module ocp_resp_ctrl_bench;

   localparam int NCH = 6;
   localparam int RST = 20;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [NCH-1:0] chan_oc;
   logic [1:0]     resp_reg, resp_pin;
   logic           resp_ovr_en, pwm_en, chip_en, clr_fault;
   logic           gate_en, flt_sticky, alert_n;
   logic [NCH-1:0] flt_mask;

   int checks = 0, failures = 0;
   bit done = 0;

   // bench model
   int             m_st, m_cnt;
   bit             m_sticky, m_pq;
   logic [NCH-1:0] m_mask;

   always #2 clk = ~clk;

   ocp_resp_ctrl #(.NCH(NCH), .RESTART_CYC(RST)) u_ocp_resp_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_oc(chan_oc), .resp_reg(resp_reg),
      .resp_ovr_en(resp_ovr_en), .resp_pin(resp_pin), .pwm_en(pwm_en),
      .chip_en(chip_en), .clr_fault(clr_fault), .gate_en(gate_en),
      .flt_sticky(flt_sticky), .flt_mask(flt_mask), .alert_n(alert_n));

   function automatic int resp_of(logic en, logic [1:0] r, logic [1:0] p);
      logic [1:0] c = en ? r : p;
      if (c == 2'b01) return 1;
      if (c == 2'b10) return 2;
      return 0;
   endfunction

   function automatic bit exp_gate();
      int md = resp_of(resp_ovr_en, resp_reg, resp_pin);
      return chip_en && pwm_en && m_st == 0 && !((|chan_oc) && md != 0);
   endfunction

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit anyf = |chan_oc;
      int md = resp_of(resp_ovr_en, resp_reg, resp_pin);
      m_mask   = (clr_fault ? '0 : m_mask) | chan_oc;
      m_sticky = (clr_fault ? 1'b0 : m_sticky) | anyf;
      if (!chip_en) begin
         m_st = 0; m_cnt = 0;
      end else begin
         case (m_st)
            0: begin
               m_cnt = 0;
               if (anyf && md == 1)      m_st = 1;
               else if (anyf && md == 2) m_st = 2;
            end
            1: begin
               if (anyf)                m_cnt = 0;
               else if (m_cnt == RST-1) begin m_st = 0; m_cnt = 0; end
               else                     m_cnt++;
            end
            default: if (pwm_en && !m_pq && !anyf) m_st = 0;
         endcase
      end
      m_pq = pwm_en;
   endtask

   // inputs were changed at a negedge; compare, take the edge, return at next negedge
   task automatic cyc(string tag);
      #0.2;
      chk({tag, " R7 gate_en"}, gate_en, exp_gate());
      chk({tag, " R3 flt_sticky"}, flt_sticky, m_sticky);
      chk({tag, " R4 flt_mask"}, flt_mask, m_mask);
      chk({tag, " R3 alert_n"}, alert_n, !m_sticky);
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      rst_n = 0; chan_oc = '0; resp_reg = 2'b00; resp_pin = 2'b00;
      resp_ovr_en = 1; pwm_en = 1; chip_en = 1; clr_fault = 0;
      m_st = 0; m_cnt = 0; m_sticky = 0; m_pq = 0; m_mask = '0;
      repeat (3) @(negedge clk);
      // R3 reset state
      chk("R3 reset sticky", flt_sticky, 0);
      chk("R3 reset alert", alert_n, 1);
      chk("R4 reset mask", flt_mask, 0);
      chk("R6 reset gate", gate_en, 1);
      rst_n = 1;
      cyc("R3");

      // R2 pin selects hiccup while register says latch-off
      resp_ovr_en = 0; resp_pin = 2'b01; resp_reg = 2'b10;
      chan_oc = 6'b000100;
      #0.2 chk("R7 gate low with fault", gate_en, 0);
      cyc("R2");
      chk("R3 sticky after fault", flt_sticky, 1);
      chk("R4 mask bit 2", flt_mask, 6'b000100);
      chan_oc = '0;
      for (int k = 0; k < RST-1; k++) cyc("R7");
      chk("R7 still waiting", gate_en, 0);
      cyc("R7");
      chk("R2 hiccup restart from pin code", gate_en, 1);

      // R8 fault during the wait restarts it
      chan_oc = 6'b100000; cyc("R8"); chan_oc = '0;
      for (int k = 0; k < 10; k++) cyc("R8");
      chan_oc = 6'b000001; cyc("R8"); chan_oc = '0;
      for (int k = 0; k < RST-1; k++) cyc("R8");
      chk("R8 wait restarted", gate_en, 0);
      cyc("R8");
      chk("R8 restart after full wait", gate_en, 1);
      chk("R4 mask accumulates", flt_mask, 6'b100101);

      // R5 clear with and without a concurrent fault
      clr_fault = 1; cyc("R5"); clr_fault = 0;
      chk("R5 cleared sticky", flt_sticky, 0);
      chk("R5 cleared mask", flt_mask, 0);
      resp_pin = 2'b00;
      chan_oc = 6'b010000; clr_fault = 1; cyc("R5"); clr_fault = 0; chan_oc = '0;
      chk("R5 fault wins over clear", flt_mask, 6'b010000);

      // R9 latch-off via register, R2 pin ignored
      resp_ovr_en = 1; resp_reg = 2'b10; resp_pin = 2'b00;
      chan_oc = 6'b001000; cyc("R9"); chan_oc = '0;
      for (int k = 0; k < RST + 10; k++) cyc("R9");
      chk("R9 no self restart", gate_en, 0);
      chan_oc = 6'b001000; pwm_en = 0; cyc("R9"); pwm_en = 1; cyc("R9");
      chan_oc = '0;
      chk("R9 toggle with fault ignored", gate_en, 0);
      pwm_en = 0; cyc("R9"); pwm_en = 1; cyc("R9");
      chk("R9 toggle recovers", gate_en, 1);

      // R10 chip enable clears latch, keeps status
      chan_oc = 6'b000010; cyc("R10"); chan_oc = '0; cyc("R10");
      chip_en = 0; cyc("R10");
      chk("R10 gate off while disabled", gate_en, 0);
      chk("R10 sticky kept", flt_sticky, 1);
      chip_en = 1; #0.2 chk("R10 gate back after enable", gate_en, 1);
      cyc("R10");

      // R1 code 11 is flag-only, R6 gate stays high
      resp_reg = 2'b11; chan_oc = 6'b111111;
      #0.2 chk("R1 code 11 flag-only", gate_en, 1);
      cyc("R6"); cyc("R6");
      chk("R6 gate with fault", gate_en, 1);
      chan_oc = '0; resp_reg = 2'b00; cyc("R1");

      // random phase
      for (int it = 0; it < 4000; it++) begin
         if ($urandom_range(29) == 0) chan_oc = NCH'($urandom_range(63, 1));
         else if ($urandom_range(3) == 0) chan_oc = '0;
         clr_fault = ($urandom_range(39) == 0);
         if ($urandom_range(79) == 0) pwm_en = ~pwm_en;
         else if (!pwm_en && $urandom_range(2) == 0) pwm_en = 1;
         if ($urandom_range(299) == 0) chip_en = 0;
         else if (!chip_en && $urandom_range(3) == 0) chip_en = 1;
         if ($urandom_range(149) == 0) begin
            resp_reg = 2'($urandom_range(3));
            resp_pin = 2'($urandom_range(3));
            resp_ovr_en = 1'($urandom_range(1));
         end
         cyc("RND");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule